// File: doc/BRIEF.md
# Vector Chaining Issue Controller

This block sits between a producing vector pipeline (for example a load unit) and a dependent consumer pipeline (for example a multiplier or a store unit). It releases the consumer one element at a time. Each element goes as soon as the matching source element has been produced, so the consumer never waits for the whole destination register to fill. A run begins with a start pulse. The pulse captures the element count for the operation and the forwarding mode. The producer then raises a strobe for each element it completes, and the controller answers with a per-element issue strobe and the index of the element being issued.

There are two forwarding modes. In bypass mode the consumer takes the value from the forwarding network, so each issue follows its producer strobe by one cycle. In register-file mode the consumer must wait for the value to be written and then read it back, which adds one more cycle to every element. Once the chain is running, producer and consumer step through the elements together, one per cycle. Each cycle carries at most one element from the single producer to the single consumer.

A three-state machine steers the run:
- **IDLE**: reached after reset.
- **RUN**: elements are counted and issued.
- **DONE**: the last element has gone out; this state holds until the next start.

The transitions are:
- **IDLE→RUN**: start with a non-zero length.
- **IDLE→DONE**: start with zero length.
- **RUN→DONE**: the last element is issued.
- **DONE→RUN**: start with a non-zero length.
- **DONE→DONE**: start with zero length.
- **any→IDLE**: synchronous reset.

Top module: `vc_chain_issue`

## Requirements
- R1: Element k is issued only after the k-th accepted producer strobe, and `issue_idx` counts 0, 1, 2, … in order with no element skipped or repeated.
- R2: When `bypass_mode` is 1 at start, a producer strobe sampled at a clock edge gives `issue` high in the cycle right after that edge (one cycle of latency).
- R3: When `bypass_mode` is 0 at start (register-file mode), `issue` rises one cycle later than in bypass mode (two cycles after the strobe edge).
- R4: Producer strobes on consecutive cycles give issues on consecutive cycles, one element per cycle. The issue of element k can fall in the same cycle as the acceptance of element k+1.
- R5: Producer strobes are ignored outside RUN and once the number of accepted strobes reaches the element count; they cause no extra issues.
- R6: A gap in the producer strobes gives an equal gap in the issue strobes for the same element, with no reordering.
- R7: The element count is taken from `vlen`. Values from 1 to 64 are used as given, values above 64 are treated as 64, and 0 moves straight to DONE with no issue.
- R8: A synchronous reset returns the machine to IDLE, clears both element counters and the forwarding pipeline, and holds `issue` and `done` low.
- R9: `start` is ignored while in RUN. Length and mode are captured only when a start is taken, so changes to `vlen` or `bypass_mode` during a run have no effect.
- R10: `done` rises in the cycle after the last element is issued and stays high until the next taken start, and `issue` is low whenever the machine is not in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new chained run (taken in IDLE or DONE) |
| vlen | input | 7 | Element count for the run, clamped to 64 |
| bypass_mode | input | 1 | 1 = forward through bypass network, 0 = through register file |
| prod_valid | input | 1 | Producer has completed its next element |
| issue | output | 1 | Consumer may start the element at `issue_idx` this cycle |
| issue_idx | output | 6 | Index of the element being issued |
| done | output | 1 | All elements of the run have been issued |

## Verification
Two functions can fall in the same cycle: acceptance of producer element k+1 and issue of consumer element k. This happens whenever the producer strobes back to back. A start request that arrives while a run is still in progress is a second case of this kind. The bench provokes both. It streams unbroken strobes in each mode, and it raises a new start with a different length and mode in the middle of a run. A behavioural queue model gives the expected issue, index and done for every cycle. The bench compares each cycle against the model, and it also checks the total number of issues for each run.

// File: rtl/vc_pkg.sv
package vc_pkg;
    typedef enum logic [1:0] {
        VC_IDLE = 2'd0,
        VC_RUN  = 2'd1,
        VC_DONE = 2'd2
    } vc_state_e;
endpackage

// File: rtl/vc_elem_counter.sv
module vc_elem_counter #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7: the count never wraps during a run
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> (cnt != '1));
endmodule

// File: rtl/vc_chain_delay.sv
module vc_chain_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    input  logic sel_bypass,
    output logic dout
);
    logic stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr) stg[i] <= 1'b0;
                else            stg[i] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || clr) stg[i] <= 1'b0;
                else            stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = sel_bypass ? stg[0] : stg[DEPTH-1];
endmodule

// File: rtl/vc_chain_issue.sv
module vc_chain_issue #(
    parameter int VL_MAX   = 64,
    parameter int RF_DEPTH = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [$clog2(VL_MAX+1)-1:0] vlen,
    input  logic                        bypass_mode,
    input  logic                        prod_valid,
    output logic                        issue,
    output logic [$clog2(VL_MAX)-1:0]   issue_idx,
    output logic                        done
);
    import vc_pkg::*;

    localparam int CW = $clog2(VL_MAX + 1);
    localparam int IW = $clog2(VL_MAX);

    vc_state_e     state, state_nx;
    logic [CW-1:0] vl_q, vl_in, pcnt, ccnt, ccnt_nx;
    logic          mode_q;
    logic          take_start, accept, chain_out, last_issue;

    assign vl_in      = (vlen > CW'(VL_MAX)) ? CW'(VL_MAX) : vlen;
    assign take_start = start && (state != VC_RUN);
    assign accept     = (state == VC_RUN) && prod_valid && (pcnt < vl_q);
    assign ccnt_nx    = ccnt + CW'(1);
    assign last_issue = chain_out && (ccnt_nx == vl_q);

    // run parameters captured only on a taken start
    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q   <= '0;
            mode_q <= 1'b1;
        end else if (take_start) begin
            vl_q   <= vl_in;
            mode_q <= bypass_mode;
        end
    end

    vc_elem_counter #(.CW(CW)) u_prod_cnt (
        .clk(clk), .rst(rst), .clr(take_start), .inc(accept), .cnt(pcnt)
    );

    vc_elem_counter #(.CW(CW)) u_cons_cnt (
        .clk(clk), .rst(rst), .clr(take_start), .inc(chain_out), .cnt(ccnt)
    );

    vc_chain_delay #(.DEPTH(RF_DEPTH)) u_delay (
        .clk(clk), .rst(rst), .clr(take_start), .din(accept),
        .sel_bypass(mode_q), .dout(chain_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= VC_IDLE;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            VC_IDLE, VC_DONE: begin
                if (take_start) state_nx = (vl_in == '0) ? VC_DONE : VC_RUN;
            end
            VC_RUN: begin
                if (last_issue) state_nx = VC_DONE;
            end
            default: state_nx = VC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue     = chain_out;
        issue_idx = ccnt[IW-1:0];
        done      = (state == VC_DONE);
    end

    p_bypass_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && mode_q) |=> issue);

    p_regfile_lat_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !mode_q) |=> ##1 issue);

    p_idx_order_r1: assert property (@(posedge clk) disable iff (rst)
        (issue && $past(issue)) |-> (issue_idx == IW'($past(issue_idx) + 1'b1)));

    p_issue_bound_r5: assert property (@(posedge clk) disable iff (rst)
        issue |-> (ccnt < vl_q));

    p_issue_in_run_r10: assert property (@(posedge clk) disable iff (rst)
        (state != VC_RUN) |-> !issue);

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

// File: tb/vc_chain_issue_tb.sv
module vc_chain_issue_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] vlen = '0;
    logic       bypass_mode = 1'b1;
    logic       prod_valid = 1'b0;
    logic       issue;
    logic [5:0] issue_idx;
    logic       done;

    always #10 clk = ~clk;

    vc_chain_issue u_dut (
        .clk(clk), .rst(rst), .start(start), .vlen(vlen),
        .bypass_mode(bypass_mode), .prod_valid(prod_valid),
        .issue(issue), .issue_idx(issue_idx), .done(done)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    n_iss    = 0;
    int    base     = 0;
    bit    cmp_en   = 1'b0;
    bit    finished = 1'b0;
    string req_tag  = "R8";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle, 1 run, 2 done
    int m_state = 0, m_pc = 0, m_cc = 0, m_vl = 0, m_lat = 1, e = 0;
    int q[$];
    bit m_issue = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_pc = 0; m_cc = 0; m_vl = 0; m_lat = 1;
            q.delete();
            m_issue = 1'b0;
        end else begin
            if (m_state != 1) begin
                if (start) begin
                    m_vl  = (vlen > 64) ? 64 : int'(vlen);
                    m_lat = bypass_mode ? 1 : 2;
                    m_pc  = 0;
                    m_cc  = 0;
                    q.delete();
                    m_state = (m_vl == 0) ? 2 : 1;
                end
            end else begin
                if (m_issue) begin
                    m_cc++;
                    if (m_cc == m_vl) m_state = 2;
                end
                if (prod_valid && m_pc < m_vl) begin
                    m_pc++;
                    q.push_back(e + m_lat - 1);
                end
            end
            m_issue = 1'b0;
            if (q.size() > 0 && q[0] == e) begin
                m_issue = 1'b1;
                void'(q.pop_front());
            end
        end
        e++;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check(issue == m_issue, req_tag, issue, m_issue);
            check(done == (m_state == 2), "R10", done, m_state == 2);
            if (m_issue) check(int'(issue_idx) == m_cc % 64, "R1", issue_idx, m_cc % 64);
            if (issue) n_iss++;
        end
    end

    task automatic go(input int vl, input bit bm);
        @(negedge clk);
        start = 1'b1; vlen = 7'(vl); bypass_mode = bm;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            prod_valid = 1'b1;
            @(negedge clk);
            if (gap > 0) begin
                prod_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        prod_valid = 1'b0;
    endtask

    task automatic snap();
        #1 base = n_iss;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        #1;
        check(issue == 1'b0, "R8", issue, 0);
        check(done == 1'b0, "R8", done, 0);
        rst = 1'b0;

        // R2 / R4: bypass, length 4, back-to-back strobes
        req_tag = "R2";
        go(4, 1'b1);
        snap();
        prod_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i == 3) prod_valid = 1'b0;
            check(issue == 1'b1, "R4", issue, 1);
        end
        @(negedge clk);
        check(done == 1'b1, "R10", done, 1);
        check(issue == 1'b0, "R10", issue, 0);
        settle(1);
        check(n_iss - base == 4, "R1", n_iss - base, 4);

        // R3: register-file mode, length 8
        req_tag = "R3";
        go(8, 1'b0);
        snap();
        prod_valid = 1'b1;
        @(negedge clk);
        check(issue == 1'b0, "R3", issue, 0);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            check(issue == 1'b1, "R3", issue, 1);
        end
        prod_valid = 1'b0;
        @(negedge clk);
        check(issue == 1'b1, "R3", issue, 1);
        @(negedge clk);
        check(done == 1'b1, "R10", done, 1);
        settle(1);
        check(n_iss - base == 8, "R3", n_iss - base, 8);

        // R6: stalled producer
        req_tag = "R6";
        go(5, 1'b1);
        snap();
        feed(5, 2);
        settle(4);
        check(n_iss - base == 5, "R6", n_iss - base, 5);

        // R5: strobes beyond length, and strobes while done
        req_tag = "R5";
        go(3, 1'b0);
        snap();
        feed(7, 0);
        settle(3);
        check(n_iss - base == 3, "R5", n_iss - base, 3);
        snap();
        feed(3, 0);
        settle(3);
        check(n_iss - base == 0, "R5", n_iss - base, 0);

        // R7: maximum length, clamp, zero length
        req_tag = "R7";
        go(64, 1'b1);
        snap();
        feed(64, 1);
        settle(4);
        check(n_iss - base == 64, "R7", n_iss - base, 64);
        go(100, 1'b0);
        snap();
        feed(70, 0);
        settle(4);
        check(n_iss - base == 64, "R7", n_iss - base, 64);
        go(0, 1'b1);
        #1 check(done == 1'b1, "R7", done, 1);
        snap();
        feed(2, 0);
        settle(3);
        check(n_iss - base == 0, "R7", n_iss - base, 0);

        // R9: start with new length/mode during a run is ignored
        req_tag = "R9";
        go(6, 1'b1);
        snap();
        feed(2, 0);
        start = 1'b1; vlen = 7'd2; bypass_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        feed(6, 0);
        settle(4);
        check(n_iss - base == 6, "R9", n_iss - base, 6);

        // R8: reset in the middle of a run
        req_tag = "R8";
        go(8, 1'b1);
        feed(3, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(issue == 1'b0, "R8", issue, 0);
        check(done == 1'b0, "R8", done, 0);
        go(2, 1'b1);
        snap();
        feed(2, 0);
        settle(3);
        check(n_iss - base == 2, "R8", n_iss - base, 2);
        check(done == 1'b1, "R10", done, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule